// File: doc/BRIEF.md
# Micro-PC Sequencer with Opcode Dispatch

This block produces the state number for the controller of a processor that runs each instruction over several clock cycles. It does not evaluate a full next-state function of state and opcode. Instead it holds a 4-bit micro-PC, and each state carries a small 2-bit selector that picks where the next micro-PC comes from. The four sources are a jump back to the fetch state, a first lookup indexed by opcode, a second lookup indexed by opcode, or the current value plus one.

The per-state selector table has sixteen entries. The two opcode lookups hold only a handful of meaningful rows. Together they replace a table addressed by opcode and state together. The surrounding controller decodes its datapath strobes from the exposed state number. The selector is exposed as well, for observation.

Top module: `useq_top`

## Requirements
- R1: A synchronous, active-high reset sampled on a rising clock edge sets the state to 0, including when it arrives in the middle of an instruction.
- R2: The selector output depends on the state as follows: state 0 gives 3, state 1 gives 1, state 2 gives 2, state 3 gives 3, state 4 gives 0, state 5 gives 0, state 6 gives 3, state 7 gives 0, state 8 gives 0, state 10 gives 3, state 11 gives 0.
- R3: When the selector is 3, the state on the next rising edge is the current state plus one.
- R4: When the selector is 0, the state on the next rising edge is 0.
- R5: When the selector is 1, the next state comes from the first lookup, indexed by the 6-bit opcode. Opcode 100011 (load) goes to 2, 101011 (store) goes to 2, 000000 (register op) goes to 6, 001011 (or-immediate) goes to 10, and 000100 (branch) goes to 8.
- R6: When the selector is 2, the next state comes from the second lookup. Opcode 100011 goes to 3 and opcode 101011 goes to 5.
- R7: When the selector is 1 and the opcode is none of the five listed in R5, the next state is 0.
- R8: When the selector is 2 and the opcode is neither 100011 nor 101011, the next state is 0.
- R9: Starting from state 0 with a steady opcode, the state sequence for each instruction class matches the explicit next-state function. Load runs 0,1,2,3,4,0. Store runs 0,1,2,5,0. Register op runs 0,1,6,7,0. Or-immediate runs 0,1,10,11,0. Branch runs 0,1,8,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction being sequenced |
| state | output | 4 | Current micro-PC (registered) |
| addr_ctl | output | 2 | Next-address selector decoded from the current state |

## Verification
The checker watches the single-step behaviour on every cycle. It covers the return to fetch after reset, increments under selector 3, returns to 0 under selector 0, the dispatch hits and misses for load and store, and the fixed selector at the fetch state. Only the bench scenarios can show that whole instruction sequences agree with an explicit next-state model for every class. They also cover a change of opcode between decode and the second dispatch, and a reset in the middle of an instruction. The unreachable state numbers (9 and 12 to 15) are covered by the selector table alone, because no input pattern can reach them.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 6;

  typedef enum logic [1:0] {
    AC_FETCH = 2'd0,
    AC_DSP1  = 2'd1,
    AC_DSP2  = 2'd2,
    AC_STEP  = 2'd3
  } addr_ctl_e;

  localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_BRANCH= 6'b000100;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_ORIMM = 6'b001011;
endpackage

// File: rtl/useq_code_rom.sv
module useq_code_rom
  import useq_pkg::*;
#(
  parameter int SW = STATE_W
) (
  input  logic [SW-1:0] state,
  output logic [1:0]    code
);
  localparam int DEPTH = 1 << SW;

  function automatic logic [1:0] entry(input int idx);
    case (idx)
      0, 3, 6, 10: entry = AC_STEP;
      1:           entry = AC_DSP1;
      2:           entry = AC_DSP2;
      default:     entry = AC_FETCH;
    endcase
  endfunction

  logic [1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = entry(i);
  end

  assign code = rom[state];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OW       = OP_W,
  parameter int SW       = STATE_W,
  parameter int TABLE_ID = 1
) (
  input  logic [OW-1:0] opcode,
  output logic [SW-1:0] target
);
  if (TABLE_ID == 1) begin : g_first
    always_comb begin
      case (opcode)
        OPC_LOAD, OPC_STORE: target = SW'(2);
        OPC_REG:             target = SW'(6);
        OPC_ORIMM:           target = SW'(10);
        OPC_BRANCH:          target = SW'(8);
        default:             target = '0;
      endcase
    end
  end else begin : g_second
    always_comb begin
      case (opcode)
        OPC_LOAD:  target = SW'(3);
        OPC_STORE: target = SW'(5);
        default:   target = '0;
      endcase
    end
  end
endmodule

// File: rtl/useq_incr.sv
module useq_incr #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] cur,
  output logic [SW-1:0] nxt
);
  assign nxt = cur + SW'(1);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int SW = STATE_W,
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  output logic [SW-1:0] state,
  output logic [1:0]    addr_ctl
);
  logic [SW-1:0] tgt1, tgt2, plus1, nxt;

  useq_code_rom #(.SW(SW)) u_rom (.state(state), .code(addr_ctl));

  useq_dispatch #(.OW(OW), .SW(SW), .TABLE_ID(1)) u_dsp1 (
    .opcode(opcode), .target(tgt1));

  useq_dispatch #(.OW(OW), .SW(SW), .TABLE_ID(2)) u_dsp2 (
    .opcode(opcode), .target(tgt2));

  useq_incr #(.SW(SW)) u_inc (.cur(state), .nxt(plus1));

  always_comb begin
    case (addr_ctl)
      AC_DSP1: nxt = tgt1;
      AC_DSP2: nxt = tgt2;
      AC_STEP: nxt = plus1;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else     state <= nxt;
  end
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
#(
  parameter int SW = STATE_W,
  parameter int OW = OP_W
) (
  input logic          clk,
  input logic          rst,
  input logic [OW-1:0] opcode,
  input logic [SW-1:0] state,
  input logic [1:0]    addr_ctl
);
  logic known1;
  assign known1 = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                  (opcode == OPC_REG) || (opcode == OPC_ORIMM) ||
                  (opcode == OPC_BRANCH);

  AST_RESET_TO_FETCH: assert property (@(posedge clk)
    rst |=> state == '0); // R1
  AST_FETCH_STEPS: assert property (@(posedge clk) disable iff (rst)
    state == '0 |-> addr_ctl == AC_STEP); // R2
  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
    addr_ctl == AC_STEP |=> state == SW'($past(state) + 1'b1)); // R3
  AST_BACK_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    addr_ctl == AC_FETCH |=> state == '0); // R4
  AST_DSP1_LOAD: assert property (@(posedge clk) disable iff (rst)
    (addr_ctl == AC_DSP1 && opcode == OPC_LOAD) |=> state == SW'(2)); // R5
  AST_DSP2_STORE: assert property (@(posedge clk) disable iff (rst)
    (addr_ctl == AC_DSP2 && opcode == OPC_STORE) |=> state == SW'(5)); // R6
  AST_DSP1_MISS: assert property (@(posedge clk) disable iff (rst)
    (addr_ctl == AC_DSP1 && !known1) |=> state == '0); // R7
  AST_DSP2_MISS: assert property (@(posedge clk) disable iff (rst)
    (addr_ctl == AC_DSP2 && opcode != OPC_LOAD && opcode != OPC_STORE)
      |=> state == '0); // R8
endmodule

bind useq_top useq_chk #(.SW(SW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .state(state), .addr_ctl(addr_ctl));

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [3:0] state;
  logic [1:0] addr_ctl;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  useq_top i_useq_top (.clk(clk), .rst(rst), .opcode(opcode),
                       .state(state), .addr_ctl(addr_ctl));

  // {opcode, length, six state nibbles}
  localparam logic [32:0] VECS [6] = '{
    {6'b100011, 3'd6, 24'h012340},
    {6'b101011, 3'd5, 24'h012500},
    {6'b000000, 3'd5, 24'h016700},
    {6'b001011, 3'd5, 24'h01AB00},
    {6'b000100, 3'd4, 24'h018000},
    {6'b111111, 3'd3, 24'h010000}
  };

  // explicit next-state function of state and opcode
  function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: case (op)
              6'b100011, 6'b101011: return 4'd2;
              6'b000000: return 4'd6;
              6'b001011: return 4'd10;
              6'b000100: return 4'd8;
              default:   return 4'd0;
            endcase
      4'd2: return (op == 6'b100011) ? 4'd3 : (op == 6'b101011) ? 4'd5 : 4'd0;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      4'd10: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] ref_code(input logic [3:0] s);
    case (s)
      4'd0, 4'd3, 4'd6, 4'd10: return 2'd3;
      4'd1: return 2'd1;
      4'd2: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] ref_s;
    do_reset();
    chk(state == 4'd0, "R1 reset state", state, 0);
    chk(addr_ctl == 2'd3, "R2 fetch code", addr_ctl, 3);

    // table walk: full instruction sequences
    foreach (VECS[v]) begin
      logic [5:0] op;
      int len;
      op = VECS[v][32:27];
      len = int'(VECS[v][26:24]);
      opcode = op;
      ref_s = 4'd0;
      for (int k = 0; k < len; k++) begin
        logic [3:0] exp_s;
        exp_s = VECS[v][23 - 4*k -: 4];
        chk(state == exp_s, "R9 sequence", state, exp_s);
        chk(state == ref_s, "R9 vs next-state model", state, ref_s);
        chk(addr_ctl == ref_code(exp_s), "R2 code per state", addr_ctl, ref_code(exp_s));
        ref_s = ref_next(ref_s, op);
        if (k < len - 1) step();
      end
      step(); // from 0 to 1 of next? keep aligned to state 0
      chk(state == 4'd1, "R3 fetch advances", state, 1);
      step();
      opcode = op;
      // drain back to state 0
      for (int k = 0; k < 8 && state != 4'd0; k++) step();
    end

    // R5 dispatch one, directed
    do_reset();
    opcode = 6'b001011;
    step();
    step();
    chk(state == 4'd10, "R5 or-imm dispatch", state, 10);
    step();
    chk(state == 4'd11, "R3 increment 10->11", state, 11);
    step();
    chk(state == 4'd0, "R4 return to fetch", state, 0);

    // R7: unknown opcode at decode
    opcode = 6'b000010;
    step();
    step();
    chk(state == 4'd0, "R7 dispatch miss", state, 0);

    // R6 and R8: opcode changes between decode and second dispatch
    do_reset();
    opcode = 6'b100011;
    step();
    step();
    chk(state == 4'd2, "R5 load dispatch", state, 2);
    opcode = 6'b101011;
    step();
    chk(state == 4'd5, "R6 store target", state, 5);
    step();
    opcode = 6'b101011;
    step();
    step();
    chk(state == 4'd2, "R5 store dispatch", state, 2);
    opcode = 6'b000000;
    step();
    chk(state == 4'd0, "R8 second dispatch miss", state, 0);

    // R1: reset mid-instruction
    opcode = 6'b100011;
    step();
    step();
    step();
    chk(state == 4'd3, "R6 load target", state, 3);
    rst = 1'b1;
    step();
    chk(state == 4'd0, "R1 reset mid-instruction", state, 0);
    rst = 1'b0;
    step();
    chk(state == 4'd1, "R3 restart after reset", state, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule